// File: doc/BRIEF.md
# Prescaled Down Counter with Terminal Count

This block is a free-running down counter whose period is set in steps of sixteen clocks. A 16-bit field, PERIOD_SEL, is written through a simple write port and can be read back at any time. The internal counter loads the value 16*PERIOD_SEL+15, steps down by one each clock and reloads once it reaches zero. Each full cycle therefore lasts 16*(PERIOD_SEL+1) clocks. The internal counter is 20 bits wide so that it can hold the largest reload value.

Each time the internal count sits at zero, the block raises a single-clock pulse on its terminal-count output. That pulse is registered and can serve as a periodic sync source elsewhere on the chip. A new PERIOD_SEL value takes effect only at the next reload, so the cycle that is under way when the write lands always finishes with its old length.

Top module: `prescaled_tc_counter`

## Requirements
- R1: After a synchronous reset, the readback shows PERIOD_SEL = 0x00FF and tc_pulse is low.
- R2: When reset is released, tc_pulse first goes high after 16*PERIOD_SEL+15 rising edges with reset low. With the default value this is 4095 edges.
- R3: After the first pulse, successive tc_pulse assertions lie exactly 16*(PERIOD_SEL+1) clocks apart. With the default value this is 4096 clocks.
- R4: tc_pulse is high for exactly one clock per cycle, and only while the internal count is zero.
- R5: A write with cfg_we high stores cfg_wdata into PERIOD_SEL at that rising edge, and cfg_rdata shows the new value from then on. With cfg_we low, cfg_rdata holds its value.
- R6: A PERIOD_SEL write that lands in the middle of a cycle leaves that cycle's length unchanged. The new value sets the length of the cycle that starts at the next reload.
- R7: The boundary values of PERIOD_SEL keep the rule. PERIOD_SEL = 0 gives the shortest period of 16 clocks, and a large value such as 0x0FFF gives 65536 clocks, which exercises the upper counter bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for PERIOD_SEL |
| cfg_wdata | input | 16 | Value to write into PERIOD_SEL |
| cfg_rdata | output | 16 | Current PERIOD_SEL contents |
| tc_pulse | output | 1 | One-clock terminal-count pulse |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running cycle. The pulse that follows must still reflect the old period, and only the pulse after it may show the new one. The stimulus waits for a chosen terminal-count pulse and then writes a fixed number of clocks later. This happens once during a 4096-clock cycle, once during a 16-clock cycle and once during a 64-clock cycle. The scoreboard queues the old period first and then the new period for each of these writes.

// File: rtl/dncnt_pkg.sv
package dncnt_pkg;
  localparam int unsigned DNCNT_SEL_W     = 16;
  localparam int unsigned DNCNT_PRE_LOG2  = 4;
  localparam logic [15:0] DNCNT_SEL_RESET = 16'h00FF;
endpackage

// File: rtl/dncnt_field_reg.sv
module dncnt_field_reg #(
  parameter int unsigned          SEL_W = 16,
  parameter logic [SEL_W-1:0]     RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] value
);
  logic [SEL_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst)     value_q <= RESET_VAL;
    else if (we) value_q <= wdata;
  end

  assign value = value_q;
endmodule

// File: rtl/dncnt_core.sv
module dncnt_core #(
  parameter int unsigned      SEL_W     = 16,
  parameter int unsigned      PRE_LOG2  = 4,
  parameter logic [SEL_W-1:0] RESET_SEL = '0,
  localparam int unsigned     TOT_W     = SEL_W + PRE_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] period_sel,
  output logic [TOT_W-1:0] cnt,
  output logic             tc
);
  localparam logic [TOT_W-1:0] RESET_LOAD = {RESET_SEL, {PRE_LOG2{1'b1}}};

  logic [TOT_W-1:0] cnt_q;
  logic [TOT_W-1:0] reload;
  logic             tc_q;

  // 16*sel+15 is a shift plus all-ones low bits: no adder needed
  assign reload = {period_sel, {PRE_LOG2{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESET_LOAD;
      tc_q  <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - TOT_W'(1);
      // registered pulse lines up with the cycle where cnt_q is zero
      tc_q <= (cnt_q == TOT_W'(1));
    end
  end

  assign cnt = cnt_q;
  assign tc  = tc_q;
endmodule

// File: rtl/prescaled_tc_counter.sv
module prescaled_tc_counter
  import dncnt_pkg::*;
#(
  parameter int unsigned      SEL_W     = DNCNT_SEL_W,
  parameter int unsigned      PRE_LOG2  = DNCNT_PRE_LOG2,
  parameter logic [SEL_W-1:0] RESET_SEL = SEL_W'(DNCNT_SEL_RESET),
  localparam int unsigned     TOT_W     = SEL_W + PRE_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_wdata,
  output logic [SEL_W-1:0] cfg_rdata,
  output logic             tc_pulse
);
  logic [SEL_W-1:0] sel_w;
  logic [TOT_W-1:0] cnt_w;

  dncnt_field_reg #(
    .SEL_W     (SEL_W),
    .RESET_VAL (RESET_SEL)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .value (sel_w)
  );

  dncnt_core #(
    .SEL_W     (SEL_W),
    .PRE_LOG2  (PRE_LOG2),
    .RESET_SEL (RESET_SEL)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .period_sel (sel_w),
    .cnt        (cnt_w),
    .tc         (tc_pulse)
  );

  assign cfg_rdata = sel_w;
endmodule

// File: rtl/prescaled_tc_counter_chk.sv
module prescaled_tc_counter_chk #(
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned PRE_LOG2 = 4,
  localparam int unsigned TOT_W   = SEL_W + PRE_LOG2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_wdata,
  input logic [SEL_W-1:0] cfg_rdata,
  input logic             tc_pulse,
  input logic [TOT_W-1:0] cnt
);
  AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);                                           // R4
  AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (cnt == '0));                                         // R4
  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - TOT_W'(1)));                  // R3
  AST_RELOAD_USES_SEL: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> (cnt == {$past(cfg_rdata), {PRE_LOG2{1'b1}}}));    // R6
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));                       // R5
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));                                   // R5
endmodule

bind prescaled_tc_counter prescaled_tc_counter_chk #(
  .SEL_W    (SEL_W),
  .PRE_LOG2 (PRE_LOG2)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .tc_pulse  (tc_pulse),
  .cnt       (cnt_w)
);

// File: tb/prescaled_tc_counter_bench.sv
module prescaled_tc_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        tc_pulse;

  typedef struct {
    int    period;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   tc_seen = 0;
  int   edges = 0;
  int   last_edge = 0;
  logic prev_tc = 1'b0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  prescaled_tc_counter u_prescaled_tc_counter (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tc_pulse  (tc_pulse)
  );

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int p, input string tag);
    exp_t e;
    e.period = p;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares tc intervals against queued periods
  always @(negedge clk) begin
    if (!rst) begin
      if (tc_pulse) begin
        check(!prev_tc, "R4 pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected pulse", edges - last_edge, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check((edges - last_edge) == e.period, e.tag, edges - last_edge, e.period);
        end
        last_edge = edges;
        tc_seen++;
      end
      prev_tc = tc_pulse;
    end
  end

  task automatic write_sel(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == v, "R5 readback after write", cfg_rdata, v);
  endtask

  task automatic wait_tc(input int n);
    while (tc_seen < n) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_rdata == 16'h00FF, "R1 reset readback", cfg_rdata, 16'h00FF);
    check(tc_pulse == 1'b0, "R1 reset tc low", tc_pulse, 0);
    push(4095, "R2 first pulse after reset");
    push(4096, "R3 default period");
    push(4096, "R3 default period");
    rst = 1'b0;
    wait_tc(2);
    repeat (100) @(negedge clk);
    write_sel(16'h0000);          // R6: third period stays 4096
    for (int i = 0; i < 4; i++) push(16, "R7 minimum period");
    wait_tc(7);
    repeat (5) @(negedge clk);
    push(16, "R6 old period kept mid-cycle");
    write_sel(16'h0003);
    @(negedge clk);
    check(cfg_rdata == 16'h0003, "R5 value held", cfg_rdata, 3);
    for (int i = 0; i < 3; i++) push(64, "R6 new period at reload");
    wait_tc(11);
    repeat (10) @(negedge clk);
    push(64, "R6 old period kept mid-cycle");
    write_sel(16'h0FFF);
    push(65536, "R7 large period");
    wait_tc(13);
    check(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R3 watchdog expired", tc_seen, 13);
    report();
  end
endmodule